// File: doc/BRIEF.md
# Conversion Status Sequencer

This block is the digital control side of a sampling converter. A host writes a 10-bit control word over a parallel bus. The bus uses an active-low chip select, a write strobe and a read strobe. The rising edge of the write strobe captures the word and starts a conversion sequence of one conversion, or of two back to back. The block reports the sequence's progress on one active-low status pin. Control bit 8 selects what that pin means. In BUSY mode the pin is a level that is low while converting. In interrupt mode the pin falls at completion and stays low until the host touches the bus again. A read drives a placeholder result onto the data bus. The result is a counter that advances once per finished conversion.

The block runs at twice the converter clock rate, so one clock cycle is half a converter period. Every delay below is given in clock cycles and is counted from E0. E0 is the first rising clock edge at which `wr_n` is sampled high after it was sampled low at the previous edge, with `cs_n` sampled low at E0. A real strobe edge falls somewhere in the cycle before E0. A count of k cycles after E0 is therefore a true delay of k to k+1 half periods. With the defaults (3, 38 and 66 cycles), BUSY falls within 1.5 to 2 periods, a single sequence ends within 19.5 periods, and a double sequence ends within 33.5 periods.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `stat_n` is 1, `db_oe` is 0, the result counter is 0 and no sequence is running.
- R2: A write strobe rise counts only when `cs_n` is sampled low at E0. If `cs_n` is high, nothing starts: `stat_n` stays high in BUSY mode and the result counter does not move.
- R3: In BUSY mode (control bit 8 = 0), `stat_n` is low after the edges E0+3 through E0+L-1 and high at all other times. L is the sequence length.
- R4: Control bit 6 sets the sequence length. When it is 0, one conversion runs and L = 38. When it is 1, two conversions run and L = 66, and completion is signalled only at E0+66.
- R5: In interrupt mode (control bit 8 = 1), `stat_n` stays high during the sequence, falls after edge E0+L, and then stays low.
- R6: A pending interrupt is released by a falling edge of `wr_n` or `rd_n` while `cs_n` is low. `stat_n` is high after the first clock edge that samples the strobe low.
- R7: A write strobe rise that comes while a sequence is running is ignored. The control word, the mode and the end time of the running sequence stay unchanged.
- R8: The result counter increases by one per finished conversion: by 1 for a single sequence and by 2 for a double sequence, wrapping at 10 bits. While `cs_n` and `rd_n` are both low, `db_out` shows the counter and `db_oe` is 1.
- R9: When `cs_n` or `rd_n` is high, `db_oe` is 0 and `db_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; its rise captures the control word |
| rd_n | input | 1 | Active-low read strobe |
| db_in | input | 10 | Control word from the host |
| db_out | output | 10 | Result value during a read, else 0 |
| db_oe | output | 1 | Data bus drive enable (high impedance when 0) |
| stat_n | output | 1 | Active-low BUSY level or interrupt |

## Verification
The bench sweeps both pin modes against both sequence lengths, with and without a write injected in the middle of the sequence. It compares `stat_n` after every edge from E0 to past the end against the edge numbers in R3 to R5. An off-by-one in the BUSY delay or in either end count would shift a transition by one edge and fail that edge's check. A design that accepted the injected write would end a double sequence at the single length, or switch the pin mode, and the trace would diverge. A design that kept interrupt mode pending would fail the read check, and so would one that ignored the write strobe as a clearing event or counted conversions wrongly. A write with chip select high must leave both the pin and the counter untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int unsigned DATA_W   = 10;
    localparam int unsigned MODE_BIT = 8;
    localparam int unsigned DBL_BIT  = 6;

    typedef enum logic {
        PIN_BUSY = 1'b0,
        PIN_IRQ  = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/adc_seq_strobe_reg.sv
// Registers the previous level of each bus strobe for edge detection.
module adc_seq_strobe_reg #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] prev_q
);
    for (genvar i = 0; i < N; i++) begin : g_strb
        logic lvl_d;
        logic lvl_q;

        always_comb begin
            lvl_d = strb_n[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b1;
            else        lvl_q <= lvl_d;
        end

        assign prev_q[i] = lvl_q;
    end
endmodule

// File: rtl/adc_seq_timer.sv
// Counts half converter periods from the accepted write and flags conversion ends.
module adc_seq_timer #(
    parameter int unsigned BUSY_DLY = 3,
    parameter int unsigned SGL_DONE = 38,
    parameter int unsigned DBL_DONE = 66,
    localparam int unsigned CNT_W   = $clog2(DBL_DONE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_dbl,
    output logic active,
    output logic busy_win_d,
    output logic conv_tick,
    output logic seq_done
);
    typedef struct packed {
        logic             active;
        logic             dbl;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        st_d      = st_q;
        last_cnt  = st_q.dbl ? CNT_W'(DBL_DONE - 1) : CNT_W'(SGL_DONE - 1);
        seq_done  = st_q.active && (st_q.cnt == last_cnt);
        conv_tick = st_q.active &&
                    ((st_q.cnt == CNT_W'(SGL_DONE - 1)) ||
                     (st_q.dbl && (st_q.cnt == CNT_W'(DBL_DONE - 1))));
        if (st_q.active) begin
            if (seq_done) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start) begin
            st_d.active = 1'b1;
            st_d.dbl    = start_dbl;
            st_d.cnt    = '0;
        end
        busy_win_d = st_d.active && (st_d.cnt >= CNT_W'(BUSY_DLY));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    // R4: a single sequence must have ended before the counter passes the single length
    a_r4_single_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.dbl) |-> (st_q.cnt < CNT_W'(SGL_DONE)));

    // R4: a sequence that ends was preceded by an end-of-conversion tick in the same cycle
    a_r4_done_is_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> $past(conv_tick));
endmodule

// File: rtl/adc_seq_status.sv
// Drives the shared active-low status pin in BUSY or interrupt mode.
module adc_seq_status
    import adc_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      busy_win_d,
    input  logic      seq_done,
    input  logic      clr,
    output logic      stat_n
);
    logic stat_d, stat_q;

    always_comb begin
        if (mode == PIN_BUSY) begin
            stat_d = ~busy_win_d;
        end else if (seq_done) begin
            stat_d = 1'b0;
        end else if (clr) begin
            stat_d = 1'b1;
        end else begin
            stat_d = stat_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= 1'b1;
        else        stat_q <= stat_d;
    end

    assign stat_n = stat_q;

    // R6: a bus strobe fall releases a pending interrupt
    a_r6_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIN_IRQ && clr && !seq_done) |=> stat_q);

    // R5: in interrupt mode the pin only falls at the end of a sequence
    a_r5_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat_q) && $past(mode) == PIN_IRQ) |-> $past(seq_done));
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top: control capture, result counter, read path.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned BUSY_DLY = 3,
    parameter int unsigned SGL_DONE = 38,
    parameter int unsigned DBL_DONE = 66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] db_in,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic              stat_n
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] result;
    } top_t;

    top_t      r_d, r_q;
    logic [1:0] prev_q;
    logic      wr_rise, wr_fall, rd_fall, accept;
    logic      active, busy_win_d, conv_tick, seq_done;
    pin_mode_e mode_eff;

    adc_seq_strobe_reg #(.N(2)) u_strb (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n ({rd_n, wr_n}),
        .prev_q (prev_q)
    );

    always_comb begin
        wr_rise  = ~prev_q[0] &  wr_n & ~cs_n;
        wr_fall  =  prev_q[0] & ~wr_n & ~cs_n;
        rd_fall  =  prev_q[1] & ~rd_n & ~cs_n;
        accept   = wr_rise & ~active;
        r_d      = r_q;
        if (accept)    r_d.ctrl   = db_in;
        if (conv_tick) r_d.result = r_q.result + 1'b1;
        mode_eff = accept ? pin_mode_e'(db_in[MODE_BIT]) : pin_mode_e'(r_q.ctrl[MODE_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    adc_seq_timer #(
        .BUSY_DLY (BUSY_DLY),
        .SGL_DONE (SGL_DONE),
        .DBL_DONE (DBL_DONE)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_dbl  (db_in[DBL_BIT]),
        .active     (active),
        .busy_win_d (busy_win_d),
        .conv_tick  (conv_tick),
        .seq_done   (seq_done)
    );

    adc_seq_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_eff),
        .busy_win_d (busy_win_d),
        .seq_done   (seq_done),
        .clr        (wr_fall | rd_fall),
        .stat_n     (stat_n)
    );

    assign db_oe  = ~cs_n & ~rd_n;
    assign db_out = db_oe ? r_q.result : '0;

    // R7: a write during a running sequence leaves the control word untouched
    a_r7_ignore_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && active) |=> $stable(r_q.ctrl));

    // R8: the result counter moves by at most one per cycle
    a_r8_result_step: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.result == $past(r_q.result)) || (r_q.result == $past(r_q.result) + 1'b1));

    // R3: a low BUSY level only occurs while a sequence is running
    a_r3_busy_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl[MODE_BIT] == 1'b0 && !stat_n) |-> active);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [9:0] db_in = '0;
    logic [9:0] db_out;
    logic       db_oe;
    logic       stat_n;

    int n_run  = 0;
    int n_fail = 0;
    int exp_result = 0;

    always #2 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .rd_n   (rd_n),
        .db_in  (db_in),
        .db_out (db_out),
        .db_oe  (db_oe),
        .stat_n (stat_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drives a write; E0 is the posedge right after return. Optionally checks the R6 release.
    task automatic write_word(input logic [9:0] w, input bit chk_clr);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; db_in = w;
        @(negedge clk);
        if (chk_clr) check("R6 wr fall releases irq", int'(stat_n), 1);
        wr_n = 1'b1;
    endtask

    task automatic read_chk(input bit irq_pending);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        check("R8 db_oe during read", int'(db_oe), 1);
        check("R8 result value", int'(db_out), exp_result % 1024);
        @(negedge clk);
        if (irq_pending) check("R6 rd fall releases irq", int'(stat_n), 1);
        rd_n = 1'b1; cs_n = 1'b1;
        #1;
        check("R9 db_oe idle", int'(db_oe), 0);
        check("R9 db_out idle", int'(db_out), 0);
    endtask

    task automatic run_seq(input bit irq, input bit dbl, input bit inject, input bit chk_clr);
        logic [9:0] w;
        int last;
        int exp;
        w = '0;
        w[8] = irq; w[6] = dbl; w[3:0] = 4'h5;
        last = dbl ? 66 : 38;
        write_word(w, chk_clr);
        for (int k = 0; k <= last + 4; k++) begin
            @(negedge clk);
            if (!irq) exp = (k >= 3 && k < last) ? 0 : 1;
            else      exp = (k < last) ? 1 : 0;
            check(irq ? (dbl ? "R5 R4 irq double trace" : "R5 irq single trace")
                      : (dbl ? "R3 R4 busy double trace" : "R3 busy single trace"),
                  int'(stat_n), exp);
            if (inject && k == 10) begin
                cs_n = 1'b0; wr_n = 1'b0; db_in = {~irq, 1'b0, ~dbl, 6'h2A};
            end else if (inject && k == 11) begin
                wr_n = 1'b1;
            end else begin
                cs_n = 1'b1;
            end
        end
        exp_result += dbl ? 2 : 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 stat_n after reset", int'(stat_n), 1);
        check("R1 db_oe after reset", int'(db_oe), 0);
        read_chk(1'b0);

        // R9: read strobe without chip select
        @(negedge clk);
        rd_n = 1'b0;
        #1;
        check("R9 rd without cs", int'(db_oe), 0);
        rd_n = 1'b1;

        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++)
                for (int j = 0; j < 2; j++) begin
                    run_seq(m[0], d[0], j[0], 1'b0);
                    read_chk(m[0]);
                end

        // R6 via write strobe: leave irq pending, then release it with the next write
        run_seq(1'b1, 1'b0, 1'b0, 1'b0);
        run_seq(1'b0, 1'b0, 1'b0, 1'b1);
        read_chk(1'b0);

        // R2: write with chip select high must not start anything
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; db_in = 10'h000;
        @(negedge clk);
        wr_n = 1'b1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            check("R2 no start without cs", int'(stat_n), 1);
        end
        read_chk(1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule